// File: doc/BRIEF.md
# Twelve-Hour Time-of-Day Counter

This block keeps the time of day in twelve-hour form. Seconds and minutes are each held as a decimal ones digit and a decimal tens digit. The hour is a binary value from 1 to 12, and a one-bit meridiem flag marks the half of the day. Time moves forward on a single-cycle one-second tick. The tick counts only in a cycle where the system clock enable is also high.

Every stage runs on one system clock. A tick that rolls the seconds over carries through the minutes and into the hour at the same clock edge, so the outputs never show a partial update or a digit outside its range. A load strobe presets every field at once. The binary hour is also given as two BCD digits, ready for a display decoder.

Top module: `tod12_counter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the time to 12:00:00 with the meridiem flag at 1 (AM). All four minute and second digits read 0.
- R2: The time advances by one second only at a clock edge where both sec_tick and clk_en are high. If either is low and load is low, every output keeps its value.
- R3: The seconds ones digit counts 0 to 9 and goes back to 0 after 9. That wrap advances the seconds tens digit.
- R4: The seconds tens digit counts 0 to 5. At xx:xx:59 a tick gives seconds 00 and advances the minutes ones digit.
- R5: The minutes ones digit counts 0 to 9 and the minutes tens digit counts 0 to 5. The minutes going from 59 back to 00 advances the hour.
- R6: The hour is binary and stays within 1 to 12. An increment from 12 gives 1 and does not change the meridiem flag. Any other increment adds one.
- R7: The meridiem flag is 1 for AM and 0 for PM. It toggles when the hour steps from 11 to 12. So 11:59:59 AM is followed by 12:00:00 PM, and 11:59:59 PM is followed by 12:00:00 AM.
- R8: The carry from seconds through minutes to the hour completes in the same clock edge as the tick.
- R9: A load strobe writes all fields in one edge and takes priority over a tick. A loaded hour outside 1 to 12 becomes 12. A loaded digit above its maximum (9 for ones digits, 5 for tens digits) becomes 0. The loaded flag is taken as given.
- R10: hour_bcd_tens and hour_bcd_ones give the current hour as decimal tens and ones, for example 12 as 1 and 2.
- R11: Reset takes priority over load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | System clock enable qualifying the tick |
| sec_tick | input | 1 | One-second tick, one cycle wide |
| load | input | 1 | Preset strobe for all fields |
| ld_sec_ones | input | 4 | Preset value, seconds ones |
| ld_sec_tens | input | 3 | Preset value, seconds tens |
| ld_min_ones | input | 4 | Preset value, minutes ones |
| ld_min_tens | input | 3 | Preset value, minutes tens |
| ld_hour | input | 4 | Preset value, binary hour |
| ld_am | input | 1 | Preset value, meridiem flag (1 = AM) |
| sec_ones | output | 4 | Seconds ones digit |
| sec_tens | output | 3 | Seconds tens digit |
| min_ones | output | 4 | Minutes ones digit |
| min_tens | output | 3 | Minutes tens digit |
| hour | output | 4 | Binary hour, 1 to 12 |
| hour_bcd_tens | output | 4 | Hour tens digit in BCD |
| hour_bcd_ones | output | 4 | Hour ones digit in BCD |
| am | output | 1 | Meridiem flag, 1 = AM, 0 = PM |

## Verification
The bench builds two copies of the block with default widths (4-bit ones digits, 3-bit tens digits, 4-bit hour). The only difference between them is the hour-to-BCD variant: one uses the shift-and-add converter, the other the compare-and-subtract converter. Every check compares the BCD digits of both copies against the hour, so both generate branches are covered. Loading a time one second before a boundary reaches every carry and meridiem corner in a few cycles. A full 3600-tick run from reset walks the complete carry chain into the hour.

// File: rtl/tod12_pkg.sv
package tod12_pkg;
   // Terminal counts of the decimal digit stages
   localparam int ONES_LAST = 9;
   localparam int TENS_LAST = 5;
   // Hour range of the twelve-hour format
   localparam int HOUR_FIRST = 1;
   localparam int HOUR_LAST  = 12;
   // Meridiem encoding
   localparam logic MER_AM = 1'b1;
   localparam logic MER_PM = 1'b0;
endpackage

// File: rtl/tod12_digit.sv
module tod12_digit #(
   parameter int W    = 4,
   parameter int LAST = 9
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q,
   output logic         wrap
);
   localparam logic [W-1:0] LAST_V = W'(LAST);

   initial begin
      assert (LAST >= 1 && LAST < (1 << W))
         else $error("tod12_digit: LAST %0d does not fit in %0d bits", LAST, W);
   end

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (ld)
         q <= (ld_val > LAST_V) ? '0 : ld_val;
      else if (inc)
         q <= (q == LAST_V) ? '0 : q + W'(1);
   end

   assign wrap = inc & (q == LAST_V);

   // R3
   digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      q <= LAST_V);

   // R3
   digit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && !ld && q == LAST_V) |=> q == '0);

   // R2
   digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!inc && !ld) |=> $stable(q));
endmodule

// File: rtl/tod12_hour.sv
module tod12_hour #(
   parameter int HW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   input  logic          ld,
   input  logic [HW-1:0] ld_hour,
   input  logic          ld_am,
   output logic [HW-1:0] hour,
   output logic          am
);
   import tod12_pkg::*;

   localparam logic [HW-1:0] TOP_V = HW'(HOUR_LAST);
   localparam logic [HW-1:0] PRE_V = HW'(HOUR_LAST - 1);
   localparam logic [HW-1:0] ONE_V = HW'(HOUR_FIRST);

   initial begin
      assert (HOUR_LAST < (1 << HW))
         else $error("tod12_hour: width %0d too small for hour", HW);
   end

   logic ld_ok;
   assign ld_ok = (ld_hour >= ONE_V) && (ld_hour <= TOP_V);

   always_ff @(posedge clk) begin
      if (rst) begin
         hour <= TOP_V;
         am   <= MER_AM;
      end else if (ld) begin
         hour <= ld_ok ? ld_hour : TOP_V;
         am   <= ld_am;
      end else if (inc) begin
         if (hour == TOP_V)
            hour <= ONE_V;
         else
            hour <= hour + HW'(1);
         if (hour == PRE_V)
            am <= ~am;
      end
   end

   // R6
   hour_range_chk: assert property (@(posedge clk) disable iff (rst)
      hour >= ONE_V && hour <= TOP_V);

   // R6
   hour_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && !ld && hour == TOP_V) |=> (hour == ONE_V && $stable(am)));

   // R7
   mer_flip_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && !ld && hour == PRE_V) |=> (hour == TOP_V && am != $past(am)));

   // R7
   mer_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!ld && !(inc && hour == PRE_V)) |=> $stable(am));
endmodule

// File: rtl/tod12_bcd.sv
module tod12_bcd #(
   parameter int HW     = 4,
   parameter bit DABBLE = 1'b1
) (
   input  logic [HW-1:0] bin,
   output logic [3:0]    tens,
   output logic [3:0]    ones
);
   initial begin
      assert (HW >= 4 && HW <= 6)
         else $error("tod12_bcd: HW %0d outside 4..6", HW);
   end

   generate
      if (DABBLE) begin : g_dabble
         logic [HW+7:0] sh;
         always_comb begin
            sh = '0;
            sh[HW-1:0] = bin;
            for (int i = 0; i < HW; i++) begin
               if (sh[HW+3:HW] >= 4'd5)
                  sh[HW+3:HW] = sh[HW+3:HW] + 4'd3;
               if (sh[HW+7:HW+4] >= 4'd5)
                  sh[HW+7:HW+4] = sh[HW+7:HW+4] + 4'd3;
               sh = sh << 1;
            end
            tens = sh[HW+7:HW+4];
            ones = sh[HW+3:HW];
         end
      end else begin : g_compare
         logic [HW+3:0] wide;
         logic [HW+3:0] rem;
         always_comb begin
            wide = (HW+4)'(bin);
            tens = '0;
            rem  = wide;
            for (int d = 9; d >= 1; d--) begin
               if (wide >= (HW+4)'(d * 10) && tens == 4'd0) begin
                  tens = 4'(d);
                  rem  = wide - (HW+4)'(d * 10);
               end
            end
            ones = rem[3:0];
         end
      end
   endgenerate

   // R10
   always_comb begin
      bcd_digit_chk: assert (ones <= 4'd9 && tens <= 4'd9 || $isunknown(bin));
   end
endmodule

// File: rtl/tod12_counter.sv
module tod12_counter #(
   parameter int ONES_W     = 4,
   parameter int TENS_W     = 3,
   parameter int HOUR_W     = 4,
   parameter bit BCD_DABBLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clk_en,
   input  logic              sec_tick,
   input  logic              load,
   input  logic [ONES_W-1:0] ld_sec_ones,
   input  logic [TENS_W-1:0] ld_sec_tens,
   input  logic [ONES_W-1:0] ld_min_ones,
   input  logic [TENS_W-1:0] ld_min_tens,
   input  logic [HOUR_W-1:0] ld_hour,
   input  logic              ld_am,
   output logic [ONES_W-1:0] sec_ones,
   output logic [TENS_W-1:0] sec_tens,
   output logic [ONES_W-1:0] min_ones,
   output logic [TENS_W-1:0] min_tens,
   output logic [HOUR_W-1:0] hour,
   output logic [3:0]        hour_bcd_tens,
   output logic [3:0]        hour_bcd_ones,
   output logic              am
);
   import tod12_pkg::*;

   localparam logic [ONES_W-1:0] ONES_END = ONES_W'(ONES_LAST);
   localparam logic [TENS_W-1:0] TENS_END = TENS_W'(TENS_LAST);

   initial begin
      assert (ONES_W >= 4 && TENS_W >= 3)
         else $error("tod12_counter: digit widths too small");
   end

   logic adv, c_so, c_st, c_mo, c_mt;
   assign adv = sec_tick & clk_en;

   tod12_digit #(.W(ONES_W), .LAST(ONES_LAST)) u_sec_ones (
      .clk(clk), .rst(rst), .inc(adv), .ld(load), .ld_val(ld_sec_ones),
      .q(sec_ones), .wrap(c_so));

   tod12_digit #(.W(TENS_W), .LAST(TENS_LAST)) u_sec_tens (
      .clk(clk), .rst(rst), .inc(c_so), .ld(load), .ld_val(ld_sec_tens),
      .q(sec_tens), .wrap(c_st));

   tod12_digit #(.W(ONES_W), .LAST(ONES_LAST)) u_min_ones (
      .clk(clk), .rst(rst), .inc(c_st), .ld(load), .ld_val(ld_min_ones),
      .q(min_ones), .wrap(c_mo));

   tod12_digit #(.W(TENS_W), .LAST(TENS_LAST)) u_min_tens (
      .clk(clk), .rst(rst), .inc(c_mo), .ld(load), .ld_val(ld_min_tens),
      .q(min_tens), .wrap(c_mt));

   tod12_hour #(.HW(HOUR_W)) u_hour (
      .clk(clk), .rst(rst), .inc(c_mt), .ld(load), .ld_hour(ld_hour),
      .ld_am(ld_am), .hour(hour), .am(am));

   tod12_bcd #(.HW(HOUR_W), .DABBLE(BCD_DABBLE)) u_bcd (
      .bin(hour), .tens(hour_bcd_tens), .ones(hour_bcd_ones));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!adv && !load) |=> ($stable(sec_ones) && $stable(sec_tens) &&
                           $stable(min_ones) && $stable(min_tens) &&
                           $stable(hour) && $stable(am)));

   // R8
   cascade_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && !load && sec_ones == ONES_END && sec_tens == TENS_END &&
       min_ones == ONES_END && min_tens == TENS_END)
      |=> (sec_ones == '0 && sec_tens == '0 && min_ones == '0 &&
           min_tens == '0 && hour != $past(hour)));

   // R4
   sec_roll_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && !load && sec_ones == ONES_END && sec_tens == TENS_END &&
       min_ones != ONES_END) |=> (min_ones == $past(min_ones) + ONES_W'(1)));
endmodule

// File: tb/tod12_counter_tb.sv
`timescale 1ns/1ps
module tod12_counter_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic clk_en = 1'b0, sec_tick = 1'b0, load = 1'b0, ld_am = 1'b0;
   logic [3:0] ld_sec_ones = '0, ld_min_ones = '0, ld_hour = '0;
   logic [2:0] ld_sec_tens = '0, ld_min_tens = '0;
   logic [3:0] sec_ones, min_ones, hour, bt, bo, bt2, bo2;
   logic [2:0] sec_tens, min_tens;
   logic am, am2;
   logic [3:0] so2, mo2, h2;
   logic [2:0] st2, mt2;
   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tod12_counter u_dut (
      .clk(clk), .rst(rst), .clk_en(clk_en), .sec_tick(sec_tick), .load(load),
      .ld_sec_ones(ld_sec_ones), .ld_sec_tens(ld_sec_tens),
      .ld_min_ones(ld_min_ones), .ld_min_tens(ld_min_tens),
      .ld_hour(ld_hour), .ld_am(ld_am),
      .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
      .min_tens(min_tens), .hour(hour), .hour_bcd_tens(bt),
      .hour_bcd_ones(bo), .am(am));

   tod12_counter #(.BCD_DABBLE(1'b0)) u_alt (
      .clk(clk), .rst(rst), .clk_en(clk_en), .sec_tick(sec_tick), .load(load),
      .ld_sec_ones(ld_sec_ones), .ld_sec_tens(ld_sec_tens),
      .ld_min_ones(ld_min_ones), .ld_min_tens(ld_min_tens),
      .ld_hour(ld_hour), .ld_am(ld_am),
      .sec_ones(so2), .sec_tens(st2), .min_ones(mo2),
      .min_tens(mt2), .hour(h2), .hour_bcd_tens(bt2),
      .hour_bcd_ones(bo2), .am(am2));

   // columns: req, ticks, start h mt mo st so am, expected h mt mo st so am
   localparam int VT[12][14] = '{
      '{3,  1,  1,0,0,0,0,1,   1,0,0,0,1,1},   // R3 single step
      '{3,  1,  1,0,0,0,9,1,   1,0,0,1,0,1},   // R3 ones wrap
      '{4,  1,  1,0,0,5,9,1,   1,0,1,0,0,1},   // R4 seconds 59 -> 00
      '{5,  1,  1,0,9,5,9,0,   1,1,0,0,0,0},   // R5 minutes ones wrap
      '{8,  1,  1,5,9,5,9,0,   2,0,0,0,0,0},   // R8 full cascade
      '{7,  1, 11,5,9,5,9,1,  12,0,0,0,0,0},   // R7 AM -> PM
      '{7,  1, 11,5,9,5,9,0,  12,0,0,0,0,1},   // R7 PM -> AM
      '{6,  1, 12,5,9,5,9,1,   1,0,0,0,0,1},   // R6 12 -> 1 keeps AM
      '{6,  1, 12,5,9,5,9,0,   1,0,0,0,0,0},   // R6 12 -> 1 keeps PM
      '{10, 1,  9,5,9,5,9,1,  10,0,0,0,0,1},   // R10 hour 10 in BCD
      '{4, 70,  3,0,4,0,5,0,   3,0,5,1,5,0},   // R4 multi-tick run
      '{5,100, 10,5,8,5,0,1,  11,0,0,3,0,1}    // R5 into next hour
   };

   task automatic check(string req, int h, int mt, int mo, int st, int so, int a);
      bit bad;
      n_run++;
      bad = (int'(hour) != h) || (int'(min_tens) != mt) || (int'(min_ones) != mo) ||
            (int'(sec_tens) != st) || (int'(sec_ones) != so) || (int'(am) != a) ||
            (int'(bt) != h / 10) || (int'(bo) != h % 10) ||
            (int'(bt2) != h / 10) || (int'(bo2) != h % 10) ||
            (int'(h2) != h) || (int'(am2) != a);
      if (bad) begin
         n_fail++;
         $display("FAIL %s: got %0d:%0d%0d:%0d%0d am=%0d bcd=%0d%0d/%0d%0d, exp %0d:%0d%0d:%0d%0d am=%0d bcd=%0d%0d",
                  req, hour, min_tens, min_ones, sec_tens, sec_ones, am, bt, bo,
                  bt2, bo2, h, mt, mo, st, so, a, h / 10, h % 10);
      end
   endtask

   task automatic set_ld(int h, int mt, int mo, int st, int so, int a);
      ld_hour = 4'(h); ld_min_tens = 3'(mt); ld_min_ones = 4'(mo);
      ld_sec_tens = 3'(st); ld_sec_ones = 4'(so); ld_am = 1'(a);
   endtask

   task automatic load_time(int h, int mt, int mo, int st, int so, int a);
      @(negedge clk);
      set_ld(h, mt, mo, st, so, a);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic run_ticks(int n);
      repeat (n) begin
         @(negedge clk);
         sec_tick = 1'b1; clk_en = 1'b1;
      end
      @(negedge clk);
      sec_tick = 1'b0; clk_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R1", 12, 0, 0, 0, 0, 1);

      for (int i = 0; i < 12; i++) begin
         load_time(VT[i][2], VT[i][3], VT[i][4], VT[i][5], VT[i][6], VT[i][7]);
         run_ticks(VT[i][1]);
         check($sformatf("R%0d", VT[i][0]), VT[i][8], VT[i][9], VT[i][10],
               VT[i][11], VT[i][12], VT[i][13]);
      end

      // R2: tick without enable, then enable without tick
      load_time(5, 0, 6, 0, 7, 0);
      @(negedge clk); sec_tick = 1'b1; clk_en = 1'b0;
      @(negedge clk); sec_tick = 1'b0;
      check("R2", 5, 0, 6, 0, 7, 0);
      @(negedge clk); clk_en = 1'b1;
      @(negedge clk); clk_en = 1'b0;
      check("R2", 5, 0, 6, 0, 7, 0);

      // R9: out-of-range hour values become 12
      load_time(0, 1, 2, 3, 4, 0);
      check("R9", 12, 1, 2, 3, 4, 0);
      load_time(13, 0, 0, 0, 0, 1);
      check("R9", 12, 0, 0, 0, 0, 1);
      // R9: digits above their maximum become 0
      load_time(7, 6, 15, 7, 12, 1);
      check("R9", 7, 0, 0, 0, 0, 1);
      // R9: load wins over a tick in the same cycle
      @(negedge clk);
      set_ld(4, 2, 2, 5, 9, 0);
      load = 1'b1; sec_tick = 1'b1; clk_en = 1'b1;
      @(negedge clk);
      load = 1'b0; sec_tick = 1'b0; clk_en = 1'b0;
      check("R9", 4, 2, 2, 5, 9, 0);

      // R11: reset wins over load
      @(negedge clk);
      set_ld(8, 3, 3, 3, 3, 0);
      rst = 1'b1; load = 1'b1;
      @(negedge clk);
      rst = 1'b0; load = 1'b0;
      check("R11", 12, 0, 0, 0, 0, 1);

      // R5 R6: one full hour of ticks from reset
      run_ticks(3600);
      check("R6", 1, 0, 0, 0, 0, 1);

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout, exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule